// File: doc/BRIEF.md
# Pipeline Register with Serial Scan Shadow

This block pairs a parallel pipeline register with a shadow register of the same width. In normal operation the pipeline register captures the parallel data input and presents it on an output port that has an active-low enable. The shadow register gives a scan path beside it. It can shift serially, take a copy of the pipeline contents, or drive its own contents out through the data port. That last use lets a word that was shifted in serially be written into a writable control store.

Each register has its own rising-edge clock, and the two clocks are independent. One mode input, together with the serial input, chooses where each register takes its data from. When mode is high the serial input acts as a control bit, and the serial output passes the serial input straight through. Tying one instance's serial output to the next instance's serial input builds a longer scan chain across several devices. The bidirectional data port is modelled as a data-in bus, a data-out bus and a drive-enable flag. A tri-stated output is modelled as a cleared valid flag with zero data. An asynchronous active-low reset clears both registers and exists only for simulation.

Top module: `scanpipe_reg`

## Requirements
- R1: While rstN is low, both the shadow register and the pipeline register are cleared to zero.
- R2: With mode low, each rising edge of dclk shifts the shadow register one place toward its top bit. Bit 0 takes sdi and bit i takes the old bit i-1.
- R3: With mode low, each rising edge of pclk loads the pipeline register from dIn.
- R4: sdo is the top shadow bit when mode is low. When mode is high, sdo equals sdi combinationally, with no register in the path.
- R5: With mode high and sdi low, a rising edge of dclk loads the shadow register from the pipeline register. This happens whatever the level of yOeN.
- R6: With mode high and sdi high, the shadow register keeps its value on dclk, and dOut carries the shadow contents with dOe high.
- R7: With mode high, a rising edge of pclk loads the pipeline register from the shadow register and does not take dIn.
- R8: dOe is low and dOut is zero in every combination other than mode high with sdi high.
- R9: When yOeN is low, yOut shows the pipeline register and yValid is 1. When yOeN is high, yOut is zero and yValid is 0.
- R10: When dclk and pclk rise together, both registers update from the values held before that edge, so their contents can be exchanged in one step.
- R11: Two instances chained sdo to sdi, with mode low, hold a 16-bit pattern intact after 16 dclk edges. The first bit shifted in ends in the top bit of the second instance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dclk | input | 1 | Shadow register clock, rising edge |
| pclk | input | 1 | Pipeline register clock, rising edge |
| rstN | input | 1 | Asynchronous active-low clear of both registers |
| mode | input | 1 | Source select for both registers |
| sdi | input | 1 | Serial input; also a control bit when mode is high |
| dIn | input | WIDTH | Parallel data input |
| dOut | output | WIDTH | Shadow contents driven toward the data port |
| dOe | output | 1 | Drive enable for dOut |
| yOeN | input | 1 | Active-low enable for the pipeline outputs |
| yOut | output | WIDTH | Pipeline register outputs, zero when disabled |
| yValid | output | 1 | High when yOut is enabled |
| sdo | output | 1 | Serial output |

## Verification
Register results appear one clock edge after the stimulus: shadow contents after the dclk pulse, and pipeline contents after the pclk pulse. Because the shadow has no output of its own, the bench reads it back through the data port by setting mode and sdi high. sdo, dOe, dOut and the yOut gating are combinational and are due in the same cycle their inputs change. The bench drives inputs while both clocks are low, applies one pulse, and hands its expected values to the scoreboard half a period after the falling edge, when every path has settled.

// File: rtl/scanpipe_pkg.sv
package scanpipe_pkg;

  typedef struct packed {
    logic shadowShift;
    logic shadowCapture;
    logic portDrive;
    logic pipeFromShadow;
    logic serialBypass;
  } strobe_t;

endpackage

// File: rtl/scanpipe_ctrl.sv
module scanpipe_ctrl
  import scanpipe_pkg::*;
(
  input  logic    mode,
  input  logic    sdi,
  output strobe_t strobe
);

  always_comb begin
    strobe                = '0;
    strobe.shadowShift    = !mode;
    strobe.shadowCapture  = mode && !sdi;
    strobe.portDrive      = mode && sdi;
    strobe.pipeFromShadow = mode;
    strobe.serialBypass   = mode;
  end

endmodule

// File: rtl/scanpipe_datapath.sv
module scanpipe_datapath
  import scanpipe_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             dclk,
  input  logic             pclk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic             sdi,
  input  logic [WIDTH-1:0] dIn,
  input  logic             yOeN,
  output logic [WIDTH-1:0] dOut,
  output logic             dOe,
  output logic [WIDTH-1:0] yOut,
  output logic             yValid,
  output logic             sdo
);

  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] shadowQ;
  logic [WIDTH-1:0] shadowNext;
  logic [WIDTH-1:0] shiftVec;
  logic [WIDTH-1:0] pipeQ;
  logic [WIDTH-1:0] pipeNext;

  for (genvar i = 0; i < WIDTH; i++) begin : g_shift
    if (i == 0) begin : g_entry
      assign shiftVec[i] = sdi;
    end else begin : g_link
      assign shiftVec[i] = shadowQ[i-1];
    end
  end

  always_comb begin
    shadowNext = shadowQ;
    if (strobe.shadowShift) begin
      shadowNext = shiftVec;
    end else if (strobe.shadowCapture) begin
      shadowNext = pipeQ;
    end
  end

  always_ff @(posedge dclk or negedge rstN) begin
    if (!rstN) begin
      shadowQ <= '0;
    end else begin
      shadowQ <= shadowNext;
    end
  end

  always_comb begin
    pipeNext = strobe.pipeFromShadow ? shadowQ : dIn;
  end

  always_ff @(posedge pclk or negedge rstN) begin
    if (!rstN) begin
      pipeQ <= '0;
    end else begin
      pipeQ <= pipeNext;
    end
  end

  assign dOe    = strobe.portDrive;
  assign dOut   = strobe.portDrive ? shadowQ : '0;
  assign yValid = !yOeN;
  assign yOut   = yOeN ? '0 : pipeQ;
  assign sdo    = strobe.serialBypass ? sdi : shadowQ[TOP];

  p_shift_r2: assert property (@(posedge dclk) disable iff (!rstN)
    strobe.shadowShift |=> shadowQ == {$past(shadowQ[TOP-1:0]), $past(sdi)});

  p_capture_r5: assert property (@(posedge dclk) disable iff (!rstN)
    strobe.shadowCapture |=> shadowQ == $past(pipeQ));

  p_hold_r6: assert property (@(posedge dclk) disable iff (!rstN)
    strobe.portDrive |=> $stable(shadowQ));

  p_pipe_load_r3: assert property (@(posedge pclk) disable iff (!rstN)
    !strobe.pipeFromShadow |=> pipeQ == $past(dIn));

  p_pipe_from_shadow_r7: assert property (@(posedge pclk) disable iff (!rstN)
    strobe.pipeFromShadow |=> pipeQ == $past(shadowQ));

  p_one_source_r8: assert property (@(posedge dclk) disable iff (!rstN)
    $countones({strobe.shadowShift, strobe.shadowCapture, strobe.portDrive}) == 1);

endmodule

// File: rtl/scanpipe_reg.sv
module scanpipe_reg
  import scanpipe_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             dclk,
  input  logic             pclk,
  input  logic             rstN,
  input  logic             mode,
  input  logic             sdi,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut,
  output logic             dOe,
  input  logic             yOeN,
  output logic [WIDTH-1:0] yOut,
  output logic             yValid,
  output logic             sdo
);

  strobe_t strobe;

  scanpipe_ctrl u_ctrl (
    .mode   (mode),
    .sdi    (sdi),
    .strobe (strobe)
  );

  scanpipe_datapath #(.WIDTH(WIDTH)) u_dp (
    .dclk   (dclk),
    .pclk   (pclk),
    .rstN   (rstN),
    .strobe (strobe),
    .sdi    (sdi),
    .dIn    (dIn),
    .yOeN   (yOeN),
    .dOut   (dOut),
    .dOe    (dOe),
    .yOut   (yOut),
    .yValid (yValid),
    .sdo    (sdo)
  );

endmodule

// File: tb/scanpipe_reg_test.sv
module scanpipe_reg_test;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic dclk = 0, pclk = 0, rstN = 0, mode = 0, sdi = 0, yOeN = 0;
  logic [W-1:0] dIn = '0;
  logic [W-1:0] dOut, yOut, dOutB, yOutB;
  logic dOe, yValid, sdo, dOeB, yValidB, sdoB;

  scanpipe_reg #(.WIDTH(W)) uut (
    .dclk(dclk), .pclk(pclk), .rstN(rstN), .mode(mode), .sdi(sdi), .dIn(dIn),
    .dOut(dOut), .dOe(dOe), .yOeN(yOeN), .yOut(yOut), .yValid(yValid), .sdo(sdo));

  scanpipe_reg #(.WIDTH(W)) uutB (
    .dclk(dclk), .pclk(pclk), .rstN(rstN), .mode(mode), .sdi(sdo), .dIn(dIn),
    .dOut(dOutB), .dOe(dOeB), .yOeN(yOeN), .yOut(yOutB), .yValid(yValidB), .sdo(sdoB));

  typedef struct {
    string       req;
    int          sel;
    logic [15:0] exp;
  } item_t;

  item_t scoreQ[$];
  event  sampleEv;
  int    testCount = 0;
  int    failCount = 0;
  bit    finished = 0;

  function automatic logic [15:0] observe(int sel);
    case (sel)
      0: return {8'h00, yOut};
      1: return {15'h0, yValid};
      2: return {15'h0, sdo};
      3: return {15'h0, dOe};
      4: return {8'h00, dOut};
      default: return {dOutB, dOut};
    endcase
  endfunction

  initial begin : monitor
    forever begin
      @(sampleEv);
      while (scoreQ.size() > 0) begin
        item_t it;
        logic [15:0] got;
        it  = scoreQ.pop_front();
        got = observe(it.sel);
        testCount++;
        if (got !== it.exp) begin
          failCount++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, got, it.exp);
        end
      end
    end
  end

  task automatic expectOut(input string req, input int sel, input logic [15:0] exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    scoreQ.push_back(it);
    #1;
    -> sampleEv;
    #1;
  endtask

  task automatic pulse(input bit doD, input bit doP);
    #(CLK_PERIOD/2);
    if (doD) dclk = 1;
    if (doP) pclk = 1;
    #(CLK_PERIOD/2);
    dclk = 0;
    pclk = 0;
    #(CLK_PERIOD/2);
  endtask

  task automatic readShadow(input string req, input logic [15:0] exp, input int sel);
    mode = 1; sdi = 1;
    expectOut(req, sel, exp);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin : driver
    logic [15:0] pat;
    #(CLK_PERIOD);
    // R1: reset clears both registers
    expectOut("R1", 0, 16'h0000);
    expectOut("R1", 1, 16'h0001);
    readShadow("R1", 16'h0000, 4);
    mode = 0; sdi = 0;
    rstN = 1;
    #(CLK_PERIOD);

    // R3: normal parallel load
    dIn = 8'hA5; pulse(0, 1);
    expectOut("R3", 0, 16'h00A5);

    // R9: output enable gating
    yOeN = 1;
    expectOut("R9", 0, 16'h0000);
    expectOut("R9", 1, 16'h0000);
    yOeN = 0;
    expectOut("R9", 1, 16'h0001);

    // R5: capture pipeline into shadow with outputs disabled
    yOeN = 1; mode = 1; sdi = 0;
    pulse(1, 0);
    yOeN = 0;
    readShadow("R5", 16'h00A5, 4);
    expectOut("R6", 3, 16'h0001);

    // R4: bypass when mode high
    expectOut("R4", 2, 16'h0001);
    sdi = 0;
    expectOut("R4", 2, 16'h0000);
    // R8: no drive in capture combination
    expectOut("R8", 3, 16'h0000);
    expectOut("R8", 4, 16'h0000);

    // R6: hold while driving, pipeline changed meanwhile
    mode = 0; dIn = 8'h3C; pulse(0, 1);
    expectOut("R3", 0, 16'h003C);
    mode = 1; sdi = 1; dIn = 8'hFF;
    pulse(1, 0);
    expectOut("R6", 4, 16'h00A5);

    // R7 + R10: simultaneous swap
    mode = 1; sdi = 0;
    pulse(1, 1);
    expectOut("R7", 0, 16'h00A5);
    readShadow("R10", 16'h003C, 4);

    // R2: shifting, R4: sdo is top shadow bit
    mode = 0; sdi = 1; pulse(1, 0);
    expectOut("R4", 2, 16'h0000);
    sdi = 0; pulse(1, 0);
    expectOut("R4", 2, 16'h0001);
    // R8: no drive with mode low and sdi high
    sdi = 1;
    expectOut("R8", 3, 16'h0000);
    expectOut("R8", 4, 16'h0000);
    readShadow("R2", 16'h00F2, 4);

    // R11: 16-bit pattern through two chained instances
    pat = 16'hC3A6;
    mode = 0;
    for (int i = 15; i >= 0; i--) begin
      sdi = pat[i];
      pulse(1, 0);
    end
    readShadow("R11", pat, 5);

    #(CLK_PERIOD);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule